// File: doc/BRIEF.md
# Fast-clock byte serializer with slow-clock edge alignment

This block sends 16-bit transmit words from a 125 MHz domain out as a stream of bytes. The bytes leave through a plain single-data-rate register clocked at 250 MHz. At the pins this looks the same as a 125 MHz double-data-rate output. The 250 MHz clock is an exact double of the 125 MHz clock and its edges come slightly earlier.

Inside the fast domain, the block samples the slow clock on every fast edge. A low-to-high change in that sample marks the fast cycle that opens a slow period. On that cycle the block latches the whole word into a holding register and drives the upper byte. On the next fast cycle it drives the lower byte of the same latched word. The output stays at zero until the sampled slow clock has alternated on two fast edges in a row, and a flag reports when alignment has been reached.

A receive companion captures a byte on each edge of the slow clock. On the following rising edge it presents the two bytes as one 16-bit word.

Top module: `ddr_sdr_tx_bridge`

## Requirements
- R1: While rst_fast is high, tx_byte and tx_aligned are 0 on the next fast edge. While rst_slow is high, rx_word is 0 on the next slow edge.
- R2: tx_aligned rises only after the sampled slow clock has alternated on two consecutive fast edges. Whenever tx_aligned is low, the next tx_byte value is 0.
- R3: A fast cycle is marked as the first half of a slow period when the slow-clock sample is 1 and the previous sample is 0. On a marked cycle, when aligned, tx_byte takes bits [15:8] of the tx_word present at that fast edge.
- R4: On the fast cycle after a marked cycle, tx_byte takes bits [7:0] of the word latched on the marked cycle. This holds even if tx_word has changed in between.
- R5: The byte on rx_byte at a slow rising edge and the byte at the following slow falling edge appear as rx_word = {rising byte, falling byte} after the next slow rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 125 MHz word clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| clk_fast | input | 1 | 250 MHz byte clock, phase-leading |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| tx_word | input | 2*BYTE_W | Transmit word from the slow domain |
| tx_byte | output | BYTE_W | Registered byte output |
| tx_aligned | output | 1 | High once byte sequencing is aligned |
| rx_byte | input | BYTE_W | DDR receive byte |
| rx_word | output | 2*BYTE_W | Assembled receive word |

## Verification
The bench builds the block with the default BYTE_W of 8. It sweeps 1024 arithmetically generated words through both directions, so every upper-byte value crosses the output several times. On each word, tx_word is replaced with its complement between the two fast cycles. This exposes any lower byte taken live instead of from the holding register. Alignment start-up is checked against the zero-output rule before the first word is sent.

// File: rtl/ddr_sdr_tx_bridge.sv
module ddr_sdr_tx_bridge #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_slow,
  input  logic                rst_slow,
  input  logic                clk_fast,
  input  logic                rst_fast,
  input  logic [2*BYTE_W-1:0] tx_word,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic                tx_aligned,
  input  logic [BYTE_W-1:0]   rx_byte,
  output logic [2*BYTE_W-1:0] rx_word
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              samp, samp_d, seen_alt, aligned_q;
  logic [WORD_W-1:0] hold;
  logic [BYTE_W-1:0] byte_q;

  wire alt        = samp ^ samp_d;
  wire first_half = samp & ~samp_d;

  always_ff @(posedge clk_fast) begin
    if (rst_fast) begin
      samp      <= 1'b0;
      samp_d    <= 1'b0;
      seen_alt  <= 1'b0;
      aligned_q <= 1'b0;
      hold      <= '0;
      byte_q    <= '0;
    end else begin
      samp      <= clk_slow;
      samp_d    <= samp;
      seen_alt  <= alt;
      aligned_q <= alt & seen_alt;
      if (first_half) hold <= tx_word;
      if (!aligned_q)      byte_q <= '0;
      else if (first_half) byte_q <= tx_word[WORD_W-1:BYTE_W];
      else                 byte_q <= hold[BYTE_W-1:0];
    end
  end

  assign tx_byte    = byte_q;
  assign tx_aligned = aligned_q;

  logic [BYTE_W-1:0] rise_b, fall_b;
  logic [WORD_W-1:0] rx_q;

  always_ff @(posedge clk_slow) begin
    if (rst_slow) begin
      rise_b <= '0;
      rx_q   <= '0;
    end else begin
      rise_b <= rx_byte;
      rx_q   <= {rise_b, fall_b};
    end
  end

  always_ff @(negedge clk_slow) begin
    if (rst_slow) fall_b <= '0;
    else          fall_b <= rx_byte;
  end

  assign rx_word = rx_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk_fast)
    rst_fast |=> (tx_byte == '0 && !tx_aligned));

  // R2
  unaligned_zero_chk: assert property (@(posedge clk_fast) disable iff (rst_fast)
    !tx_aligned |=> (tx_byte == '0));

  // R3
  high_first_chk: assert property (@(posedge clk_fast) disable iff (rst_fast)
    (tx_aligned && first_half) |=> (tx_byte == $past(tx_word[WORD_W-1:BYTE_W])));

  // R4
  low_held_chk: assert property (@(posedge clk_fast) disable iff (rst_fast)
    (tx_aligned && first_half) |=> ##1 (tx_byte == $past(tx_word[BYTE_W-1:0], 2)));
endmodule

// File: tb/ddr_sdr_tx_bridge_tb.sv
module ddr_sdr_tx_bridge_tb;
  localparam int BW = 8;
  localparam int N  = 1024;

  logic clk_slow = 1'b0, clk_fast = 1'b0;
  logic rst_slow = 1'b1, rst_fast = 1'b1;
  logic [2*BW-1:0] tx_word = '0;
  logic [BW-1:0]   rx_byte = '0;
  logic [BW-1:0]   tx_byte;
  logic            tx_aligned;
  logic [2*BW-1:0] rx_word;
  int checks = 0, failures = 0;

  ddr_sdr_tx_bridge #(.BYTE_W(BW)) u_dut (
    .clk_slow(clk_slow), .rst_slow(rst_slow), .clk_fast(clk_fast), .rst_fast(rst_fast),
    .tx_word(tx_word), .tx_byte(tx_byte), .tx_aligned(tx_aligned),
    .rx_byte(rx_byte), .rx_word(rx_word));

  initial begin #3; forever #4 clk_slow = ~clk_slow; end
  initial forever #2 clk_fast = ~clk_fast;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] txw(input int k);
    logic [9:0] kk = k[9:0];
    return {kk[7:0], kk[9:2] ^ 8'hA5};
  endfunction

  function automatic logic [15:0] rxw(input int k);
    logic [9:0] kk = k[9:0];
    return {kk[9:2] ^ 8'h3C, kk[7:0] + 8'h11};
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_slow);
    #1;
    check("R1 tx_byte in reset", tx_byte, 0);
    check("R1 tx_aligned in reset", tx_aligned, 0);
    check("R1 rx_word in reset", rx_word, 0);
    tx_word = 16'hBEEF;
    rst_fast = 1'b0;
    rst_slow = 1'b0;
    #4;
    check("R2 zero before alignment", tx_byte, 0);
    check("R2 flag low before alignment", tx_aligned, 0);
    repeat (4) @(negedge clk_slow);
    #1;
    check("R2 aligned after alternations", tx_aligned, 1);
    for (int k = 0; k < N; k++) begin
      @(negedge clk_slow);
      #1;
      if (k > 0) check("R4 low byte from held word", tx_byte, txw(k-1) & 16'h00FF);
      tx_word = txw(k);
      rx_byte = rxw(k) >> 8;
      @(posedge clk_slow);
      #1;
      check("R3 high byte first", tx_byte, txw(k) >> 8);
      if (k > 0) check("R5 rx word assembly", rx_word, rxw(k-1));
      tx_word = ~txw(k);
      rx_byte = rxw(k) & 16'h00FF;
    end
    @(negedge clk_slow);
    #1;
    check("R4 final low byte", tx_byte, txw(N-1) & 16'h00FF);
    @(posedge clk_slow);
    #1;
    check("R5 final rx word", rx_word, rxw(N-1));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule